// File: doc/BRIEF.md
# Read-Strobe Delay Window Trainer

This sequencer picks the read-strobe delay for each byte lane of a DDR interface. It needs a fixed eight-byte training pattern to be in memory already. For each lane it sweeps a 5-bit delay upward from zero. At every step it reads the whole pattern back through a simple request/acknowledge read port. Before each byte read it flushes the PHY read FIFO and clears the controller's sticky status flags.

A search sweep finds the lowest delay at which all eight bytes return intact. A second sweep then keeps stepping until the first corrupted read, which marks the far edge of the passing window. The lane's delay is then set to the middle of that window. Lanes are trained one after another. A single `start` pulse runs the whole job, and `done` or `error` reports the result.

Top module: `strobe_window_trainer`

## Requirements
- R1: While reset is asserted, and while idle after reset, `done`, `error`, `rd_req`, `fifo_rst` and `stat_clr` are 0 and every lane delay is 0.
- R2: Byte i (0..7) of lane L is requested at address BASE_ADDR + L + 4*i; the bench uses BASE_ADDR = 0.
- R3: The expected bytes, in read order i = 0..7, are 0xFE, 0x11, 0x33, 0x55, 0x77, 0x99, 0xBB, 0xDD. A read fails if the returned byte differs from the expected byte, if `rd_masked` is 1, or if `rd_dummy` is 1. All three causes lead to the same result.
- R4: Every byte read is preceded by a one-cycle cycle in which both `fifo_rst` and `stat_clr` are 1 and `rd_req` is 0.
- R5: The search sweep starts each lane at delay 0. On a failed read the delay steps up by one and the pattern restarts at byte 0. When all eight bytes pass, the current delay is stored as the window start.
- R6: The pass sweep starts at the window start and steps the delay up after each fully passing pattern. On the first failed read the lane delay becomes start + ((current − start) >> 1), and one further `fifo_rst`-only pulse follows. A lane that succeeds therefore sees exactly one more `fifo_rst` pulse than it has reads.
- R7: If either sweep needs to step the delay past 31, training stops with `error` = 1 and that lane's delay left at 31.
- R8: Lane 0 is trained before lane 1. `done` rises only after the last lane has been centred. An error stops training, so later lanes keep delay 0.
- R9: After `done` or `error`, the delays hold their values. A new `start` clears every delay to 0, and clears `done` and `error`, on the following clock edge.
- R10: `rd_req` stays high with a stable address until a cycle with `rd_ack` = 1. The returned data and flags are sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin training all lanes (accepted when idle) |
| done | output | 1 | All lanes trained successfully |
| error | output | 1 | A delay saturated; training stopped |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | ADDR_W | Byte address of the request |
| rd_ack | input | 1 | Read completed; data and flags valid this cycle |
| rd_data | input | 8 | Returned byte |
| rd_masked | input | 1 | Masked-data status flag for this read |
| rd_dummy | input | 1 | Dummy-data status flag for this read |
| fifo_rst | output | 1 | PHY read FIFO reset pulse |
| stat_clr | output | 1 | Clear sticky controller status |
| lane_dly | output | LANES*DLY_W | Per-lane delay, lane 0 in the low bits |

## Verification
The memory model returns good data when a lane's current delay lies inside a configured window. Outside the window it corrupts one chosen byte, by flipping its data, by raising the masked flag or by raising the dummy flag, so the three failure causes are shown to be equivalent. Moving the corrupted byte from 0 to 7 shows that a late failure still restarts the pattern at byte 0. Windows at delay 0, at delay 31, a one-step window and a lane with no window at all separate the centring arithmetic from the two saturation exits. The count of FIFO pulses against reads confirms the per-read flush and the extra pulse after centring.

// File: rtl/strobe_window_trainer.sv
module strobe_window_trainer #(
  parameter int LANES     = 2,
  parameter int DLY_W     = 5,
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   done,
  output logic                   error,
  output logic                   rd_req,
  output logic [ADDR_W-1:0]      rd_addr,
  input  logic                   rd_ack,
  input  logic [7:0]             rd_data,
  input  logic                   rd_masked,
  input  logic                   rd_dummy,
  output logic                   fifo_rst,
  output logic                   stat_clr,
  output logic [LANES*DLY_W-1:0] lane_dly
);

  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int IDX_W  = 3;
  localparam int STRIDE = 4;
  localparam logic [DLY_W-1:0]  DLY_TOP   = '1;
  localparam logic [IDX_W-1:0]  IDX_LAST  = '1;
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);

  typedef enum logic [1:0] {S_IDLE, S_FLUSH, S_READ, S_SETTLE} state_t;

  state_t            state;
  logic              in_pass;
  logic [LANE_W-1:0] lane;
  logic [IDX_W-1:0]  idx;
  logic [DLY_W-1:0]  win_lo;
  logic [DLY_W-1:0]  dly_q [LANES];

  function automatic logic [7:0] golden(input logic [IDX_W-1:0] i);
    case (i)
      3'd0:    golden = 8'hFE;
      3'd1:    golden = 8'h11;
      3'd2:    golden = 8'h33;
      3'd3:    golden = 8'h55;
      3'd4:    golden = 8'h77;
      3'd5:    golden = 8'h99;
      3'd6:    golden = 8'hBB;
      default: golden = 8'hDD;
    endcase
  endfunction

  logic [DLY_W-1:0] cur, mid;
  logic             bad, last_byte, at_top;

  assign cur       = dly_q[lane];
  assign mid       = win_lo + ((cur - win_lo) >> 1);
  assign bad       = rd_masked | rd_dummy | (rd_data != golden(idx));
  assign last_byte = (idx == IDX_LAST);
  assign at_top    = (cur == DLY_TOP);

  assign rd_req   = (state == S_READ);
  assign stat_clr = (state == S_FLUSH);
  assign fifo_rst = (state == S_FLUSH) || (state == S_SETTLE);
  assign rd_addr  = ADDR_W'(BASE_ADDR) + ADDR_W'(lane) + ADDR_W'(idx) * ADDR_W'(STRIDE);

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign lane_dly[g*DLY_W +: DLY_W] = dly_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      error   <= 1'b0;
      in_pass <= 1'b0;
      lane    <= '0;
      idx     <= '0;
      win_lo  <= '0;
      for (int k = 0; k < LANES; k++) dly_q[k] <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          done    <= 1'b0;
          error   <= 1'b0;
          in_pass <= 1'b0;
          lane    <= '0;
          idx     <= '0;
          win_lo  <= '0;
          for (int k = 0; k < LANES; k++) dly_q[k] <= '0;
          state   <= S_FLUSH;
        end
        S_FLUSH: state <= S_READ;
        S_READ: if (rd_ack) begin
          if (!in_pass) begin
            if (bad) begin
              if (at_top) begin
                error <= 1'b1;
                state <= S_IDLE;
              end else begin
                dly_q[lane] <= cur + 1'b1;
                idx         <= '0;
                state       <= S_FLUSH;
              end
            end else if (last_byte) begin
              win_lo  <= cur;
              in_pass <= 1'b1;
              idx     <= '0;
              state   <= S_FLUSH;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_FLUSH;
            end
          end else begin
            if (bad) begin
              dly_q[lane] <= mid;
              state       <= S_SETTLE;
            end else if (last_byte) begin
              if (at_top) begin
                error <= 1'b1;
                state <= S_IDLE;
              end else begin
                dly_q[lane] <= cur + 1'b1;
                idx         <= '0;
                state       <= S_FLUSH;
              end
            end else begin
              idx   <= idx + 1'b1;
              state <= S_FLUSH;
            end
          end
        end
        S_SETTLE: begin
          if (lane == LANE_LAST) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            lane    <= lane + 1'b1;
            idx     <= '0;
            in_pass <= 1'b0;
            state   <= S_FLUSH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/swt_checker.sv
module swt_checker #(
  parameter int LANES  = 2,
  parameter int DLY_W  = 5,
  parameter int ADDR_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   done,
  input logic                   error,
  input logic                   rd_req,
  input logic                   rd_ack,
  input logic [ADDR_W-1:0]      rd_addr,
  input logic                   fifo_rst,
  input logic                   stat_clr,
  input logic [LANES*DLY_W-1:0] lane_dly
);

  a_r4_no_req_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |-> !rd_req);

  a_r4_clr_with_flush: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |-> fifo_rst);

  a_r4_flush_before_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> $past(fifo_rst && stat_clr));

  a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  a_r8_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  a_r8_quiet_when_finished: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !(rd_req || fifo_rst));

  a_r9_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    ((done || error) && !start) |=> $stable(lane_dly));

endmodule

bind strobe_window_trainer swt_checker #(
  .LANES(LANES), .DLY_W(DLY_W), .ADDR_W(ADDR_W)
) u_swt_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
  .rd_req(rd_req), .rd_ack(rd_ack), .rd_addr(rd_addr), .fifo_rst(fifo_rst),
  .stat_clr(stat_clr), .lane_dly(lane_dly)
);

// File: tb/tb_strobe_window_trainer.sv
module tb_strobe_window_trainer;
  localparam int LANES = 2, DLY_W = 5, ADDR_W = 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic done, error, rd_req, fifo_rst, stat_clr;
  logic [ADDR_W-1:0] rd_addr;
  logic rd_ack = 0, rd_masked = 0, rd_dummy = 0;
  logic [7:0] rd_data = 0;
  logic [LANES*DLY_W-1:0] lane_dly;

  strobe_window_trainer #(.LANES(LANES), .DLY_W(DLY_W), .ADDR_W(ADDR_W), .BASE_ADDR(0)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_masked(rd_masked), .rd_dummy(rd_dummy), .fifo_rst(fifo_rst),
    .stat_clr(stat_clr), .lane_dly(lane_dly));

  always #10 clk = ~clk;

  // lo0 hi0 lo1 hi1 kind fbyte lat | err d0 d1 finished_lanes
  localparam int NV = 6, NF = 11;
  localparam int VEC [NV][NF] = '{
    '{ 5, 12,  8, 20, 0, 3, 0,  0,  9, 14, 2},
    '{ 0,  0, 30, 30, 1, 0, 1,  0,  0, 30, 2},
    '{ 3, 31,  0,  5, 0, 2, 0,  1, 31,  0, 0},
    '{ 2,  6, 32, 40, 2, 5, 2,  1,  4, 31, 1},
    '{10, 17,  1,  2, 2, 7, 1,  0, 14,  2, 2},
    '{31, 31,  4,  9, 1, 4, 0,  1, 31,  0, 0}
  };

  int checks = 0, errors = 0;
  int cfg_lo[2], cfg_hi[2];
  int cfg_kind = 0, cfg_fb = 0, cfg_lat = 0;
  int wait_cnt = 0, pulses = 0, reads = 0, proto = 0;
  bit saw_rst = 0, saw_clr = 0, cnt_clear = 0;

  function automatic logic [7:0] expect_byte(input int i);
    expect_byte = (i == 0) ? 8'hFE : 8'(8'h11 * (2 * i - 1));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    rd_ack = 0; rd_masked = 0; rd_dummy = 0;
    if (!rst_n) begin
      wait_cnt = 0; saw_rst = 0; saw_clr = 0;
    end else begin
      if (cnt_clear) begin pulses = 0; reads = 0; proto = 0; end
      if (fifo_rst) begin pulses++; saw_rst = 1; end
      if (stat_clr) saw_clr = 1;
      if (rd_req) begin
        if (wait_cnt >= cfg_lat) begin
          int ln, bi, d;
          rd_ack = 1; wait_cnt = 0; reads++;
          if (!saw_rst || !saw_clr) proto++;
          saw_rst = 0; saw_clr = 0;
          ln = int'(rd_addr[1:0]); bi = int'(rd_addr[4:2]);
          if (rd_addr > 31 || ln > 1) rd_data = 8'h00;
          else begin
            d = int'(lane_dly[ln*DLY_W +: DLY_W]);
            rd_data = expect_byte(bi);
            if (!(d >= cfg_lo[ln] && d <= cfg_hi[ln]) && bi == cfg_fb) begin
              case (cfg_kind)
                0: rd_data = expect_byte(bi) ^ 8'h80;
                1: rd_masked = 1;
                default: rd_dummy = 1;
              endcase
            end
          end
        end else wait_cnt++;
      end else wait_cnt = 0;
    end
  end

  task automatic setup(input int v);
    cfg_lo[0] = VEC[v][0]; cfg_hi[0] = VEC[v][1];
    cfg_lo[1] = VEC[v][2]; cfg_hi[1] = VEC[v][3];
    cfg_kind = VEC[v][4]; cfg_fb = VEC[v][5]; cfg_lat = VEC[v][6];
  endtask

  task automatic launch();
    @(negedge clk); #1 cnt_clear = 1;
    @(negedge clk); #1 cnt_clear = 0; start = 1;
    @(negedge clk); #1 start = 0;
  endtask

  task automatic wait_end();
    while (!(done || error)) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 error in reset", int'(error), 0);
    chk("R1 rd_req in reset", int'(rd_req), 0);
    chk("R1 pulses in reset", int'(fifo_rst | stat_clr), 0);
    chk("R1 delays in reset", int'(lane_dly), 0);
    #1 rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle rd_req", int'(rd_req), 0);

    for (int v = 0; v < NV; v++) begin
      setup(v);
      launch();
      wait_end();
      @(negedge clk);
      chk($sformatf("R7 R8 error v%0d", v), int'(error), VEC[v][7]);
      chk($sformatf("R8 done v%0d", v), int'(done), 1 - VEC[v][7]);
      chk($sformatf("R3 R5 R6 lane0 delay v%0d", v), int'(lane_dly[4:0]), VEC[v][8]);
      chk($sformatf("R2 R6 R8 lane1 delay v%0d", v), int'(lane_dly[9:5]), VEC[v][9]);
      chk($sformatf("R6 fifo pulses v%0d", v), pulses, reads + VEC[v][10]);
      chk($sformatf("R4 R10 flush per read v%0d", v), proto, 0);
    end

    // R9: hold after done, clear on new start
    setup(0);
    launch();
    wait_end();
    repeat (20) @(negedge clk);
    chk("R9 hold lane0", int'(lane_dly[4:0]), 9);
    chk("R9 hold lane1", int'(lane_dly[9:5]), 14);
    chk("R9 done held", int'(done), 1);
    #1 start = 1;
    @(negedge clk);
    chk("R9 delays cleared by start", int'(lane_dly), 0);
    chk("R9 done cleared by start", int'(done), 0);
    #1 start = 0;
    wait_end();
    @(negedge clk);
    chk("R9 rerun lane1", int'(lane_dly[9:5]), 14);

    // R1: reset mid-run
    setup(4);
    launch();
    repeat (40) @(negedge clk);
    #1 rst_n = 0;
    @(negedge clk);
    chk("R1 mid-run reset delays", int'(lane_dly), 0);
    chk("R1 mid-run reset rd_req", int'(rd_req), 0);
    chk("R1 mid-run reset fifo_rst", int'(fifo_rst), 0);
    #1 rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 idle after reset", int'(rd_req | done | error), 0);

    summary();
  end
endmodule